// File: doc/BRIEF.md
# Port Statistics Snapshot and Readout Unit

This unit keeps a set of 32-bit traffic counters for each switch port. Each counter advances by one on a single-cycle event pulse. A management agent works the unit through three 16-bit registers: a command register and two result registers. A command either freezes every counter of one port into a capture bank, or picks one captured counter and places its value in the result registers.

A snapshot copies one counter per clock. The busy flag in bit 15 of the command register stays set until the copy is complete. The live counters keep counting while the copy runs and afterwards. Readouts come only from the frozen bank, so a group of counters read one after another all belong to the same moment per counter. Software that needs a 64-bit total keeps it as two 32-bit entries at consecutive indices, with the low word at the lower index.

A read command is busy for one clock. After that, the value sits split across the two result registers. Every operation finishes well inside a polling window of ten reads of the busy flag.

Top module: `stats_snapshot_unit`

## Requirements
- R1: After synchronous reset, all live counters, the capture bank, the command register and both result registers read as zero, and the unit is not busy.
- R2: Register address 0 reads as {busy, the low 15 bits of the last accepted command}. Busy reads 1 from the clock after a command is accepted until that operation has finished.
- R3: A write to address 0 whose bits 15:10 equal 6'b110111 (0xDC00 with the port in bits 7:0) starts a snapshot of that port. Capture entry k receives live counter k of that port on the (k+1)-th clock after the write. Busy stays set for exactly NUM_CNTRS clocks, which is at most ten.
- R4: A write to address 0 whose bits 15:10 equal 6'b110011 (0xCC00 with the counter index in bits 7:0) loads that captured entry into the result. Busy is set for exactly one clock.
- R5: Address 1 returns result bits 31:16 and address 2 returns result bits 15:0. Address 3 reads as zero.
- R6: Live counters count during and after a snapshot. Captured values and the result stay unchanged until the next snapshot or read command.
- R7: A read whose index is NUM_CNTRS or more returns zero and still clears busy. A snapshot of a port number NUM_PORTS or more captures zeros.
- R8: A write to address 0 while busy is ignored. The operation in flight and the command readback do not change.
- R9: A write to address 0 with any other value of bits 15:10, and any write to addresses 1 to 3, starts nothing and leaves the command readback unchanged.
- R10: Live counter k of port p advances by one on each clock where event bit p*NUM_CNTRS+k is high, and wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_wr | input | 1 | Register write strobe |
| mgmt_addr | input | 2 | Register address: 0 command, 1 result high, 2 result low |
| mgmt_wdata | input | 16 | Register write data |
| mgmt_rdata | output | 16 | Read data of the addressed register (combinational) |
| cnt_evt | input | NUM_PORTS*NUM_CNTRS | Counter increment pulses, bit p*NUM_CNTRS+k for counter k of port p |

## Verification
The bench drives event patterns of four kinds: none, every counter at once, one port only, and random bits. With no events, any captured value can be predicted exactly. With every counter pulsing, the count passes 2^16, which shows whether the high and low result halves land in the right registers. Random and single-port traffic during a snapshot shows whether each entry is taken on its own copy clock and whether a port's events leak into another port's bank. Re-reading one index while traffic continues separates a frozen bank from a live one. Out-of-range indices, out-of-range ports, commands written while busy and bad opcodes test the rejection paths.

// File: rtl/stats_pkg.sv
package stats_pkg;

    localparam int CNT_W = 32;
    localparam int REG_W = 16;

    localparam logic [5:0] OPC_SNAP = 6'b110111;
    localparam logic [5:0] OPC_READ = 6'b110011;

    localparam logic [1:0] RA_OP = 2'd0;
    localparam logic [1:0] RA_HI = 2'd1;
    localparam logic [1:0] RA_LO = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SNAP = 2'd1,
        ST_READ = 2'd2
    } st_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_SNAP = 2'd1,
        CMD_READ = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        logic [REG_W-1:0] hi;
        logic [REG_W-1:0] lo;
    } result_t;

    function automatic cmd_kind_e decode_cmd(input logic [REG_W-1:0] w);
        if (w[15:10] == OPC_SNAP)      return CMD_SNAP;
        else if (w[15:10] == OPC_READ) return CMD_READ;
        else                           return CMD_NONE;
    endfunction

endpackage

// File: rtl/stats_live_bank.sv
module stats_live_bank
    import stats_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_CNTRS = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PORTS*NUM_CNTRS-1:0] evt,
    input  logic [7:0]                     rd_port,
    input  logic [$clog2(NUM_CNTRS)-1:0]   rd_idx,
    output logic [CNT_W-1:0]               rd_val
);
    localparam int TOTAL = NUM_PORTS * NUM_CNTRS;
    localparam int IDX_W = $clog2(NUM_CNTRS);

    logic [CNT_W-1:0] cnt [TOTAL];

    for (genvar g = 0; g < TOTAL; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)         cnt[g] <= '0;
            else if (evt[g]) cnt[g] <= cnt[g] + 1'b1;
        end
    end

    // Out-of-range port selects nothing and yields zero.
    always_comb begin
        rd_val = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int c = 0; c < NUM_CNTRS; c++) begin
                if (rd_port == 8'(p) && rd_idx == IDX_W'(c))
                    rd_val = cnt[p*NUM_CNTRS + c];
            end
        end
    end

endmodule

// File: rtl/stats_capture_bank.sv
module stats_capture_bank
    import stats_pkg::*;
#(
    parameter int NUM_CNTRS = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [$clog2(NUM_CNTRS)-1:0] wr_idx,
    input  logic [CNT_W-1:0]             wr_val,
    input  logic [7:0]                   rd_sel,
    output logic [CNT_W-1:0]             rd_val
);
    localparam int IDX_W = $clog2(NUM_CNTRS);

    logic [CNT_W-1:0] cap [NUM_CNTRS];

    for (genvar g = 0; g < NUM_CNTRS; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst)                                  cap[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))    cap[g] <= wr_val;
        end
    end

    // Indices past the bank match no entry and read as zero.
    always_comb begin
        rd_val = '0;
        for (int c = 0; c < NUM_CNTRS; c++) begin
            if (rd_sel == 8'(c)) rd_val = cap[c];
        end
    end

endmodule

// File: rtl/stats_ctrl.sv
module stats_ctrl
    import stats_pkg::*;
#(
    parameter int NUM_CNTRS = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr,
    input  logic [1:0]                   addr,
    input  logic [REG_W-1:0]             wdata,
    output logic                         busy,
    output logic [REG_W-2:0]             op_q,
    output logic                         snap_en,
    output logic [$clog2(NUM_CNTRS)-1:0] snap_idx,
    output logic [7:0]                   snap_port,
    output logic                         res_load,
    output logic [7:0]                   rd_sel
);
    localparam int IDX_W = $clog2(NUM_CNTRS);

    st_e              st_q;
    logic [IDX_W-1:0] cnt_q;
    logic [7:0]       port_q;
    logic [7:0]       sel_q;
    cmd_kind_e        kind;

    assign kind = decode_cmd(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            port_q <= '0;
            sel_q  <= '0;
            op_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (wr && addr == RA_OP) begin
                        case (kind)
                            CMD_SNAP: begin
                                st_q   <= ST_SNAP;
                                cnt_q  <= '0;
                                port_q <= wdata[7:0];
                                op_q   <= wdata[REG_W-2:0];
                            end
                            CMD_READ: begin
                                st_q  <= ST_READ;
                                sel_q <= wdata[7:0];
                                op_q  <= wdata[REG_W-2:0];
                            end
                            default: ;
                        endcase
                    end
                end
                ST_SNAP: begin
                    if (cnt_q == IDX_W'(NUM_CNTRS - 1)) st_q <= ST_IDLE;
                    else                                cnt_q <= cnt_q + 1'b1;
                end
                ST_READ: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign snap_en   = (st_q == ST_SNAP);
    assign snap_idx  = cnt_q;
    assign snap_port = port_q;
    assign res_load  = (st_q == ST_READ);
    assign rd_sel    = sel_q;

endmodule

// File: rtl/stats_snapshot_unit.sv
module stats_snapshot_unit
    import stats_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_CNTRS = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           mgmt_wr,
    input  logic [1:0]                     mgmt_addr,
    input  logic [15:0]                    mgmt_wdata,
    output logic [15:0]                    mgmt_rdata,
    input  logic [NUM_PORTS*NUM_CNTRS-1:0] cnt_evt
);
    localparam int IDX_W = $clog2(NUM_CNTRS);

    logic             busy;
    logic [14:0]      op_q;
    logic             snap_en;
    logic [IDX_W-1:0] snap_idx;
    logic [7:0]       snap_port;
    logic             res_load;
    logic [7:0]       rd_sel;
    logic [CNT_W-1:0] live_val;
    logic [CNT_W-1:0] cap_val;
    result_t          res_q;

    stats_ctrl #(.NUM_CNTRS(NUM_CNTRS)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr        (mgmt_wr),
        .addr      (mgmt_addr),
        .wdata     (mgmt_wdata),
        .busy      (busy),
        .op_q      (op_q),
        .snap_en   (snap_en),
        .snap_idx  (snap_idx),
        .snap_port (snap_port),
        .res_load  (res_load),
        .rd_sel    (rd_sel)
    );

    stats_live_bank #(.NUM_PORTS(NUM_PORTS), .NUM_CNTRS(NUM_CNTRS)) i_live (
        .clk     (clk),
        .rst     (rst),
        .evt     (cnt_evt),
        .rd_port (snap_port),
        .rd_idx  (snap_idx),
        .rd_val  (live_val)
    );

    stats_capture_bank #(.NUM_CNTRS(NUM_CNTRS)) i_cap (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (snap_en),
        .wr_idx (snap_idx),
        .wr_val (live_val),
        .rd_sel (rd_sel),
        .rd_val (cap_val)
    );

    always_ff @(posedge clk) begin
        if (rst)           res_q <= '0;
        else if (res_load) res_q <= result_t'(cap_val);
    end

    always_comb begin
        case (mgmt_addr)
            RA_OP:   mgmt_rdata = {busy, op_q};
            RA_HI:   mgmt_rdata = res_q.hi;
            RA_LO:   mgmt_rdata = res_q.lo;
            default: mgmt_rdata = '0;
        endcase
    end

endmodule

// File: rtl/stats_snapshot_checker.sv
module stats_snapshot_checker #(
    parameter int NUM_CNTRS = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        mgmt_wr,
    input logic [1:0]  mgmt_addr,
    input logic [15:0] mgmt_wdata,
    input logic [15:0] mgmt_rdata,
    input logic        busy,
    input logic [14:0] op_q,
    input logic [31:0] res_q
);
    logic op_wr;
    assign op_wr = !busy && mgmt_wr && (mgmt_addr == 2'd0);

    AST_BUSY_READBACK: assert property (@(posedge clk) disable iff (rst)
        (mgmt_addr == 2'd0) |-> (mgmt_rdata[15] == busy)); // R2

    AST_SNAP_STARTS: assert property (@(posedge clk) disable iff (rst)
        (op_wr && mgmt_wdata[15:10] == 6'b110111) |=> busy); // R3

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (op_wr && mgmt_wdata[15:10] == 6'b110011) |=> busy ##1 !busy); // R4

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(res_q)); // R6

    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_wr && mgmt_wdata[15:10] == 6'b110011 && mgmt_wdata[7:0] >= 8'(NUM_CNTRS))
        |-> ##2 (res_q == 32'd0 && !busy)); // R7

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (busy && mgmt_wr) |=> $stable(op_q)); // R8

    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (op_wr && mgmt_wdata[15:10] != 6'b110111 && mgmt_wdata[15:10] != 6'b110011)
        |=> (!busy && $stable(op_q))); // R9

endmodule

bind stats_snapshot_unit stats_snapshot_checker #(.NUM_CNTRS(NUM_CNTRS)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .mgmt_wr    (mgmt_wr),
    .mgmt_addr  (mgmt_addr),
    .mgmt_wdata (mgmt_wdata),
    .mgmt_rdata (mgmt_rdata),
    .busy       (busy),
    .op_q       (op_q),
    .res_q      (res_q)
);

// File: tb/test_stats_snapshot_unit.sv
`timescale 1ns/1ps
module test_stats_snapshot_unit;
    localparam int NP = 4;
    localparam int NC = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mgmt_wr = 1'b0;
    logic [1:0]        mgmt_addr = 2'd0;
    logic [15:0]       mgmt_wdata = 16'd0;
    logic [15:0]       mgmt_rdata;
    logic [NP*NC-1:0]  cnt_evt = '0;

    int n_run  = 0;
    int n_fail = 0;
    int evt_mode = 0;
    bit cmp_en = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stats_snapshot_unit #(.NUM_PORTS(NP), .NUM_CNTRS(NC)) i_stats_snapshot_unit (
        .clk        (clk),
        .rst        (rst),
        .mgmt_wr    (mgmt_wr),
        .mgmt_addr  (mgmt_addr),
        .mgmt_wdata (mgmt_wdata),
        .mgmt_rdata (mgmt_rdata),
        .cnt_evt    (cnt_evt)
    );

    // Behavioural reference model
    logic [31:0] m_live [NP][NC];
    logic [31:0] m_cap  [NC];
    int          m_st, m_cnt, m_port, m_sel;
    logic [14:0] m_op;
    logic [31:0] m_res;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_live[p, c]) m_live[p][c] = 32'd0;
            foreach (m_cap[c]) m_cap[c] = 32'd0;
            m_st = 0; m_cnt = 0; m_port = 0; m_sel = 0; m_op = '0; m_res = '0;
        end else begin
            if (m_st == 1) begin
                m_cap[m_cnt] = (m_port < NP) ? m_live[m_port][m_cnt] : 32'd0;
                if (m_cnt == NC - 1) m_st = 0;
                else m_cnt++;
            end else if (m_st == 2) begin
                m_res = (m_sel < NC) ? m_cap[m_sel] : 32'd0;
                m_st = 0;
            end else if (mgmt_wr && mgmt_addr == 2'd0) begin
                if (mgmt_wdata[15:10] == 6'b110111) begin
                    m_st = 1; m_cnt = 0; m_port = int'(mgmt_wdata[7:0]); m_op = mgmt_wdata[14:0];
                end else if (mgmt_wdata[15:10] == 6'b110011) begin
                    m_st = 2; m_sel = int'(mgmt_wdata[7:0]); m_op = mgmt_wdata[14:0];
                end
            end
            for (int p = 0; p < NP; p++)
                for (int c = 0; c < NC; c++)
                    if (cnt_evt[p*NC+c]) m_live[p][c] = m_live[p][c] + 32'd1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (cmp_en && !rst) begin
                logic [15:0] e;
                case (mgmt_addr)
                    2'd0:    e = {(m_st != 0), m_op};
                    2'd1:    e = m_res[31:16];
                    2'd2:    e = m_res[15:0];
                    default: e = 16'd0;
                endcase
                if (mgmt_addr == 2'd0) chk("R2 model busy/command", {16'd0, mgmt_rdata}, {16'd0, e});
                else                   chk("R5 model result regs", {16'd0, mgmt_rdata}, {16'd0, e});
            end
        end
    end

    // Event pattern generator (R10)
    initial begin
        forever begin
            @(negedge clk);
            #0.2;
            case (evt_mode)
                1:       cnt_evt = '1;
                2:       cnt_evt = NP*NC'($urandom);
                3:       cnt_evt = {{(NP-2)*NC{1'b0}}, {NC{1'b1}}, {NC{1'b0}}};
                default: cnt_evt = '0;
            endcase
        end
    end

    task automatic write_reg(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        mgmt_wr = 1'b1; mgmt_addr = a; mgmt_wdata = v;
        @(negedge clk);
        mgmt_wr = 1'b0; mgmt_addr = 2'd0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        mgmt_addr = a;
        #1 v = mgmt_rdata;
    endtask

    // Count the polls seen with busy set, starting right after a write.
    task automatic poll(output int n);
        n = 0;
        mgmt_addr = 2'd0;
        #1;
        while (mgmt_rdata[15] && n < 50) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic read_ctr(input int idx, output logic [31:0] v);
        int n;
        logic [15:0] h, l;
        write_reg(2'd0, 16'hCC00 | 16'(idx));
        poll(n);
        chk("R4 read busy one cycle", 32'(n), 32'd1);
        read_reg(2'd1, h);
        read_reg(2'd2, l);
        v = {h, l};
    endtask

    task automatic snap(input int port);
        int n;
        write_reg(2'd0, 16'hDC00 | 16'(port));
        poll(n);
        chk("R3 snapshot busy cycles", 32'(n), 32'(NC));
    endtask

    initial begin
        logic [15:0] r;
        logic [31:0] v, v1;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_en = 1;
        read_reg(2'd0, r); chk("R1 reset command reg", {16'd0, r}, 32'd0);
        read_reg(2'd1, r); chk("R1 reset result hi", {16'd0, r}, 32'd0);
        read_reg(2'd2, r); chk("R1 reset result lo", {16'd0, r}, 32'd0);
        read_ctr(0, v);    chk("R1 reset capture entry", v, 32'd0);

        // Every counter pulses past 2^16
        evt_mode = 1;
        repeat (70000) @(negedge clk);
        evt_mode = 0;
        repeat (2) @(negedge clk);
        write_reg(2'd0, 16'hDC02);
        chk("R2 busy after command", {31'd0, mgmt_rdata[15]}, 32'd1);
        poll(n);
        chk("R3 snapshot busy cycles", 32'(n), 32'(NC));
        read_ctr(5, v);
        chk("R5 upper half in hi reg", {16'd0, v[31:16]}, 32'd1);
        chk("R10 counter value", v, m_live[2][5]);
        read_reg(2'd3, r); chk("R5 unused address", {16'd0, r}, 32'd0);

        // Frozen bank while port 1 counts
        snap(1);
        read_ctr(3, v1);
        evt_mode = 3;
        repeat (50) @(negedge clk);
        read_ctr(3, v);
        chk("R6 capture frozen", v, v1);
        snap(1);
        evt_mode = 0;
        read_ctr(3, v);
        chk("R6 fresh snapshot differs", {31'd0, (v != v1)}, 32'd1);

        // Out of range
        read_ctr(8'h40, v);  chk("R7 index beyond bank", v, 32'd0);
        read_reg(2'd0, r);   chk("R7 busy cleared", {31'd0, r[15]}, 32'd0);
        snap(9);
        read_ctr(2, v);      chk("R7 absent port zeros", v, 32'd0);

        // Write while busy
        write_reg(2'd0, 16'hDC01);
        write_reg(2'd0, 16'hCC05);
        poll(n);
        read_reg(2'd0, r);   chk("R8 command ignored while busy", {16'd0, r}, 32'h5C01);

        // Bad opcode and writes elsewhere
        write_reg(2'd0, 16'h1234);
        chk("R9 bad opcode not busy", {31'd0, mgmt_rdata[15]}, 32'd0);
        read_reg(2'd0, r);   chk("R9 command unchanged", {16'd0, r}, 32'h5C01);
        write_reg(2'd1, 16'hCC00);
        chk("R9 write to result reg ignored", {31'd0, mgmt_rdata[15]}, 32'd0);

        // Random traffic with snapshots over all ports
        evt_mode = 2;
        for (int p = 0; p < NP; p++) begin
            snap(p);
            for (int c = 0; c < NC; c++) begin
                read_ctr(c, v);
                chk("R3 random capture", v, m_cap[c]);
            end
        end
        evt_mode = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("[TB] FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule